// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block is the command front end of a byte-wide NOR flash. It watches the chip-enable, write-enable and output-enable strobes, gathers bus writes into multi-cycle instructions guarded by a two-write unlock preamble, and turns valid instructions into program, block erase and chip erase jobs for a program/erase engine. The engine drives an abstract array port with a start pulse, an operation code, an address and a data byte, and waits for the array to report completion. A per-job cycle limit turns a job that never completes into a reported error.

While a job runs, the ready output is low. A read of the device then returns a status byte instead of array data. A running block erase can be parked: the array may then be read, or programmed outside the erased block, before the erase continues. An identification mode returns fixed maker and device codes. All bus inputs are taken as synchronous to `clk_i`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode with `ready_o` high, and a read (`ce_ni`=0, `oe_ni`=0, `we_ni`=1) returns `rd_data_i` for the address on `addr_i`.
- R2: A program takes four writes: AAh at low address 555h, 55h at 2AAh, A0h at 555h, then the target address and byte. The cycle after the fourth write, `arr_start_o` pulses and `arr_op_o`=1 with that address and byte on `arr_addr_o` and `arr_data_o`.
- R3: An erase takes six writes: unlock pair, 80h at 555h, unlock pair again, then 30h at any address in the block (block erase, `arr_op_o`=2) or 10h at 555h (chip erase, `arr_op_o`=3).
- R4: A wrong data code or wrong unlock address at any step drops the partial sequence and returns to array-read mode. No job starts.
- R5: `ready_o` is low from the cycle after a job is accepted until the cycle after `arr_done_i`. While it is low, every write other than suspend (B0h) and, in error state, read/reset (F0h) is ignored.
- R6: A read during a job returns status. Bit 7 is the inverse of bit 7 of the byte being programmed (0 for erase). Bit 6 inverts after every status read. Bit 5 flags an error. Bit 3 is high while an erase runs. Bit 2 inverts after each status read of an erase.
- R7: B0h during a block erase parks it: `arr_op_o` returns to 0 and `ready_o` goes high. Reads outside the erased block return array data. Reads inside it return status with bit 7 high and bit 2 toggling. A program outside the block runs and then returns to the parked state. A program inside the block is dropped. A single 30h write restarts the erase. B0h during chip erase is ignored.
- R8: The unlock pair followed by 90h at 555h enters identification mode. Reads at address bits [1:0]=0, 1 and 2 return `MAKER_ID`, `DEVICE_ID` and 00h. Any other single write, such as F0h, returns to array-read mode.
- R9: If `arr_done_i` does not arrive within `TIMEOUT` active cycles, the job is abandoned: status bit 5 reads 1 and `ready_o` stays low until an F0h write.
- R10: Asserting `rst_ni` abandons any job at once. While reset is held, `ready_o` and `arr_op_o` are 0. After release the block is in array-read mode.
- R11: A write's address is taken when the later of `ce_ni`/`we_ni` falls. Its data is taken when the earlier of the two rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Bus address |
| data_i | input | 8 | Write data / command byte |
| data_o | output | 8 | Read data: array, status or identification |
| data_oe_o | output | 1 | High while a read drives `data_o` |
| ready_o | output | 1 | High when no job is running |
| rd_addr_o | output | AW | Array read address |
| rd_data_i | input | 8 | Array read data |
| arr_start_o | output | 1 | One-cycle pulse when a job (re)starts |
| arr_op_o | output | 2 | 0 none, 1 program, 2 block erase, 3 chip erase |
| arr_addr_o | output | AW | Job address |
| arr_data_o | output | 8 | Program byte |
| arr_done_i | input | 1 | Array reports the job finished |

## Verification
On every cycle, the assertions check four things: how a write is captured, how a broken unlock falls back to idle, that a start pulse always carries an operation, and how the engine moves on done, on timeout and on a parked block erase. Only the bench scenarios can show the rest, because it depends on the order of whole sequences. That covers writes ignored while busy, the status bits toggling across separate reads, programs inside and outside a parked erase, identification reads, and recovery after a timeout or a mid-job reset. A cycle-level reference model of `ready_o` runs beside the design and is compared on every clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_BLK, OP_CHIP} arr_op_e;
  typedef enum logic [2:0] {E_IDLE, E_PROG, E_ERASE, E_SUSP, E_SPROG, E_ERR} eng_st_e;

  localparam int DW = 8;
  localparam int UW = 12;  // address bits compared in unlock cycles

  localparam logic [DW-1:0] C_UNL_A  = 8'hAA;
  localparam logic [DW-1:0] C_UNL_B  = 8'h55;
  localparam logic [DW-1:0] C_PROG   = 8'hA0;
  localparam logic [DW-1:0] C_ERASE  = 8'h80;
  localparam logic [DW-1:0] C_IDENT  = 8'h90;
  localparam logic [DW-1:0] C_RESET  = 8'hF0;
  localparam logic [DW-1:0] C_BLK    = 8'h30;
  localparam logic [DW-1:0] C_CHIP   = 8'h10;
  localparam logic [DW-1:0] C_SUSP   = 8'hB0;
  localparam logic [DW-1:0] C_RESUME = 8'h30;
  localparam logic [UW-1:0] A_UNL_A  = 12'h555;
  localparam logic [UW-1:0] A_UNL_B  = 12'h2AA;
endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_v_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          rd_act_o,
  output logic          rd_end_o
);
  logic wr_act, wr_q, rd_q;
  logic [AW-1:0] addr_q;

  assign wr_act   = ~ce_ni & ~we_ni;
  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act_o;
      if (wr_act && !wr_q) addr_q <= addr_i;  // later of the two falls
    end
  end

  // data taken when the earlier strobe rises
  assign cmd_v_o    = wr_q & ~wr_act;
  assign cmd_addr_o = addr_q;
  assign cmd_data_o = data_i;
  assign rd_end_o   = rd_q & ~rd_act_o;

  p_addr_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && !wr_q) |=> cmd_addr_o == $past(addr_i));
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_v_i,
  input  logic [UW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          busy_i,
  input  logic          susp_i,
  output logic          req_prog_o,
  output logic          req_blk_o,
  output logic          req_chip_o,
  output logic          req_susp_o,
  output logic          req_resume_o,
  output logic          req_reset_o,
  output logic          ident_o
);
  typedef enum logic [2:0] {S_IDLE, S_UNL1, S_UNL2, S_PRG, S_ERA0, S_ERA1, S_ERA2} seq_e;
  seq_e seq_q, seq_d;
  logic ident_d, is_unl_a, is_unl_b, at_unl;

  assign at_unl   = cmd_addr_i == A_UNL_A;
  assign is_unl_a = at_unl && cmd_data_i == C_UNL_A;
  assign is_unl_b = cmd_addr_i == A_UNL_B && cmd_data_i == C_UNL_B;

  always_comb begin
    seq_d        = seq_q;
    ident_d      = ident_o;
    req_prog_o   = 1'b0;
    req_blk_o    = 1'b0;
    req_chip_o   = 1'b0;
    req_susp_o   = 1'b0;
    req_resume_o = 1'b0;
    req_reset_o  = 1'b0;
    if (cmd_v_i) begin
      seq_d = S_IDLE;
      if (busy_i) begin
        req_susp_o  = cmd_data_i == C_SUSP;
        req_reset_o = cmd_data_i == C_RESET;
      end else begin
        unique case (seq_q)
          S_IDLE: if (is_unl_a) seq_d = S_UNL1;
                  else begin
                    ident_d      = 1'b0;
                    req_resume_o = susp_i && cmd_data_i == C_RESUME;
                  end
          S_UNL1: if (is_unl_b) seq_d = S_UNL2; else ident_d = 1'b0;
          S_UNL2: begin
            ident_d = 1'b0;
            if (at_unl) begin
              if (cmd_data_i == C_PROG) seq_d = S_PRG;
              else if (cmd_data_i == C_ERASE && !susp_i) seq_d = S_ERA0;
              else if (cmd_data_i == C_IDENT && !susp_i) ident_d = 1'b1;
            end
          end
          S_PRG:  req_prog_o = 1'b1;
          S_ERA0: if (is_unl_a) seq_d = S_ERA1;
          S_ERA1: if (is_unl_b) seq_d = S_ERA2;
          S_ERA2: begin
            req_blk_o  = cmd_data_i == C_BLK;
            req_chip_o = cmd_data_i == C_CHIP && at_unl;
          end
          default: seq_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q   <= S_IDLE;
      ident_o <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      ident_o <= ident_d;
    end
  end

  p_bad_unlock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_v_i && !busy_i && seq_q == S_UNL1 && !is_unl_b) |=> (seq_q == S_IDLE && !ident_o));
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 20,
  parameter int BLK_LSB = 16,
  parameter int TIMEOUT = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_prog_i,
  input  logic          req_blk_i,
  input  logic          req_chip_i,
  input  logic          req_susp_i,
  input  logic          req_resume_i,
  input  logic          req_reset_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          arr_done_i,
  output logic          arr_start_o,
  output logic [1:0]    arr_op_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_data_o,
  output eng_st_e       st_o,
  output logic [AW-1:0] ers_addr_o,
  output logic          last_prog_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  eng_st_e st_q;
  arr_op_e ers_kind_q, op;
  logic [AW-1:0] prg_addr_q, ers_addr_q;
  logic [DW-1:0] prg_data_q;
  logic [CW-1:0] cnt_q;
  logic active, timeout_hit, same_blk;

  always_comb begin
    unique case (st_q)
      E_PROG, E_SPROG: op = OP_PROG;
      E_ERASE:         op = ers_kind_q;
      default:         op = OP_NONE;
    endcase
  end

  assign active      = op != OP_NONE;
  assign timeout_hit = active && !arr_done_i && cnt_q == CW'(TIMEOUT - 1);
  assign same_blk    = req_addr_i[AW-1:BLK_LSB] == ers_addr_q[AW-1:BLK_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= E_IDLE;
      ers_kind_q  <= OP_BLK;
      prg_addr_q  <= '0;
      ers_addr_q  <= '0;
      prg_data_q  <= '0;
      cnt_q       <= '0;
      arr_start_o <= 1'b0;
      last_prog_o <= 1'b0;
    end else begin
      arr_start_o <= 1'b0;
      cnt_q       <= active ? cnt_q + 1'b1 : '0;
      unique case (st_q)
        E_IDLE: begin
          if (req_prog_i) begin
            prg_addr_q <= req_addr_i; prg_data_q <= req_data_i;
            st_q <= E_PROG; arr_start_o <= 1'b1; last_prog_o <= 1'b1;
          end else if (req_blk_i || req_chip_i) begin
            ers_addr_q <= req_addr_i;
            ers_kind_q <= req_chip_i ? OP_CHIP : OP_BLK;
            st_q <= E_ERASE; arr_start_o <= 1'b1; last_prog_o <= 1'b0;
          end
        end
        E_PROG:  if (arr_done_i) st_q <= E_IDLE; else if (timeout_hit) st_q <= E_ERR;
        E_ERASE: begin
          if (arr_done_i) st_q <= E_IDLE;
          else if (timeout_hit) st_q <= E_ERR;
          else if (req_susp_i && ers_kind_q == OP_BLK) st_q <= E_SUSP;
        end
        E_SUSP: begin
          if (req_prog_i && !same_blk) begin
            prg_addr_q <= req_addr_i; prg_data_q <= req_data_i;
            st_q <= E_SPROG; arr_start_o <= 1'b1; last_prog_o <= 1'b1;
          end else if (req_resume_i) begin
            st_q <= E_ERASE; arr_start_o <= 1'b1; last_prog_o <= 1'b0;
          end
        end
        E_SPROG: if (arr_done_i) st_q <= E_SUSP; else if (timeout_hit) st_q <= E_ERR;
        E_ERR:   if (req_reset_i) st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign arr_op_o   = op;
  assign arr_addr_o = (st_q == E_ERASE) ? ers_addr_q : prg_addr_q;
  assign arr_data_o = prg_data_q;
  assign st_o       = st_q;
  assign ers_addr_o = ers_addr_q;

  p_start_has_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> arr_op_o != OP_NONE);
  p_done_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_PROG && arr_done_i) |=> (arr_op_o == OP_NONE && !arr_start_o));
  p_timeout_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_hit |=> st_q == E_ERR);
  p_suspend_parks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_ERASE && req_susp_i && ers_kind_q == OP_BLK && !arr_done_i && !timeout_hit)
      |=> (st_q == E_SUSP && arr_op_o == OP_NONE));
  p_same_blk_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_SUSP && req_prog_i && same_blk) |=> st_q == E_SUSP);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          BLK_LSB   = 16,
  parameter int          TIMEOUT   = 4096,
  parameter logic [7:0]  MAKER_ID  = 8'h3C,
  parameter logic [7:0]  DEVICE_ID = 8'hA7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic          ready_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          arr_start_o,
  output logic [1:0]    arr_op_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_data_o,
  input  logic          arr_done_i
);
  logic cmd_v, rd_act, rd_end, ident;
  logic [AW-1:0] cmd_addr, ers_addr;
  logic [DW-1:0] cmd_data, status, rd_mux;
  logic req_prog, req_blk, req_chip, req_susp, req_resume, req_reset, last_prog;
  logic busy, susp, same_blk, stat_sel, b7, t6_q, t2_q;
  eng_st_e st;

  flash_bus_if #(.AW(AW)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .cmd_v_o(cmd_v), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  flash_cmd_dec u_dec (
    .clk_i, .rst_ni, .cmd_v_i(cmd_v), .cmd_addr_i(cmd_addr[UW-1:0]),
    .cmd_data_i(cmd_data), .busy_i(busy), .susp_i(susp),
    .req_prog_o(req_prog), .req_blk_o(req_blk), .req_chip_o(req_chip),
    .req_susp_o(req_susp), .req_resume_o(req_resume), .req_reset_o(req_reset),
    .ident_o(ident)
  );

  flash_pe_engine #(.AW(AW), .BLK_LSB(BLK_LSB), .TIMEOUT(TIMEOUT)) u_eng (
    .clk_i, .rst_ni, .req_prog_i(req_prog), .req_blk_i(req_blk), .req_chip_i(req_chip),
    .req_susp_i(req_susp), .req_resume_i(req_resume), .req_reset_i(req_reset),
    .req_addr_i(cmd_addr), .req_data_i(cmd_data), .arr_done_i,
    .arr_start_o, .arr_op_o, .arr_addr_o, .arr_data_o,
    .st_o(st), .ers_addr_o(ers_addr), .last_prog_o(last_prog)
  );

  assign busy     = st inside {E_PROG, E_ERASE, E_SPROG, E_ERR};
  assign susp     = st == E_SUSP || st == E_SPROG;
  assign same_blk = addr_i[AW-1:BLK_LSB] == ers_addr[AW-1:BLK_LSB];
  assign stat_sel = busy || (st == E_SUSP && same_blk);
  assign ready_o  = rst_ni & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (rd_end) begin
      if (busy) t6_q <= ~t6_q;
      if (st == E_ERASE || (st == E_SUSP && same_blk)) t2_q <= ~t2_q;
    end
  end

  assign b7     = busy ? (last_prog & ~arr_data_o[7]) : 1'b1;
  assign status = {b7, t6_q, st == E_ERR, 1'b0, st == E_ERASE, t2_q, 2'b00};

  always_comb begin
    if (stat_sel)   rd_mux = status;
    else if (ident) rd_mux = addr_i[1] ? 8'h00 : (addr_i[0] ? DEVICE_ID : MAKER_ID);
    else            rd_mux = rd_data_i;
  end

  assign data_oe_o = rd_act & rst_ni;
  assign data_o    = data_oe_o ? rd_mux : 8'h00;
  assign rd_addr_o = addr_i;
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int LAT  = 30;
  localparam int TOUT = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  data_o, arr_data, rd_data;
  logic        data_oe, ready, arr_start, arr_done = 1'b0, stall = 1'b0;
  logic [1:0]  arr_op;
  logic [19:0] rd_addr, arr_addr;
  logic        ref_ready = 1'b1, fin = 1'b0;
  int n_tests = 0, n_fail = 0, rcnt = 0;

  always #2 clk = ~clk;

  assign rd_data = rd_addr[7:0] ^ 8'h5A;

  flash_cmd_seq #(.TIMEOUT(TOUT)) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(wdata), .data_o(data_o), .data_oe_o(data_oe),
    .ready_o(ready), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .arr_start_o(arr_start), .arr_op_o(arr_op), .arr_addr_o(arr_addr),
    .arr_data_o(arr_data), .arr_done_i(arr_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // array responder: done after LAT active cycles since the last start
  always @(negedge clk) begin
    arr_done = 1'b0;
    if (!rst_n) rcnt = 0;
    else if (arr_start) rcnt = 0;
    else if (arr_op != 2'd0 && !stall) begin
      rcnt++;
      if (rcnt == LAT) begin arr_done = 1'b1; ref_ready = 1'b1; end
    end
  end

  // reference model of ready, compared every clock (R5)
  always @(posedge clk) begin
    #1;
    chk("R5 ready_o per-cycle", ready, rst_n ? ref_ready : 1'b0);
  end

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 d = data_o;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unl();
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55);
  endtask

  task automatic prog(input logic [19:0] a, input logic [7:0] d);
    unl(); wr(20'h00555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    unl(); wr(20'h00555, 8'h80); unl();
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 300 && ready !== 1'b1; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op_chk(input string tag, input logic [1:0] exp);
    @(negedge clk); #1 chk(tag, arr_op, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s1, s2, d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, array read
    @(negedge clk); #1 chk("R1 ready after reset", ready, 1);
    rd(20'h00123, d); chk("R1 array read", d, 8'h79);

    // R2 / R11: program; address moves and data changes while the write is held low
    unl(); wr(20'h00555, 8'hA0);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 20'h12345; wdata = 8'h00;
    @(negedge clk); addr = 20'h0FFFF; wdata = 8'h3C;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; ref_ready = 1'b0;
    @(negedge clk); #1;
    chk("R2 op program", arr_op, 1);
    chk("R11 address at falling edge", arr_addr, 20'h12345);
    chk("R11 data at rising edge", arr_data, 8'h3C);

    // R6: status during program
    rd(20'h12345, s1); rd(20'h12345, s2);
    chk("R6 bit7 inverse of data", s1[7], 1);
    chk("R6 bit5 no error", s1[5], 0);
    chk("R6 bit3 not erasing", s1[3], 0);
    chk("R6 bit6 toggles", s1[6] ^ s2[6], 1);

    // R5: erase sequence while busy is ignored
    erase_pre(); wr(20'h20000, 8'h30);
    wait_ready();
    repeat (6) @(negedge clk);
    #1 chk("R5 ignored command started nothing", arr_op, 0);

    // R4: bad code and bad unlock address
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h54); wr(20'h00555, 8'hA0); wr(20'h00300, 8'h11);
    op_chk("R4 bad code no job", 0);
    rd(20'h00300, d); chk("R4 read array after bad code", d, 8'h5A);
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55); wr(20'h00555, 8'hA0); wr(20'h00301, 8'h22);
    op_chk("R4 bad address no job", 0);
    rd(20'h00301, d); chk("R4 read array after bad address", d, 8'h5B);

    // R3: block erase
    erase_pre(); wr(20'h20010, 8'h30); ref_ready = 1'b0;
    @(negedge clk); #1;
    chk("R3 op block erase", arr_op, 2);
    chk("R3 erase address", arr_addr, 20'h20010);
    rd(20'h20000, s1);
    chk("R6 bit3 erasing", s1[3], 1);
    chk("R6 bit7 zero on erase", s1[7], 0);

    // R7: suspend
    wr(20'h00000, 8'hB0); ref_ready = 1'b1;
    op_chk("R7 suspend parks array", 0);
    rd(20'h30044, d); chk("R7 read other block", d, 8'h1E);
    rd(20'h20000, s1); rd(20'h20000, s2);
    chk("R7 erased block bit7", s1[7], 1);
    chk("R7 erased block bit2 toggles", s1[2] ^ s2[2], 1);

    // R7: program inside erased block dropped, outside runs
    prog(20'h21000, 8'h55);
    op_chk("R7 same block program dropped", 0);
    prog(20'h40000, 8'h80); ref_ready = 1'b0;
    @(negedge clk); #1;
    chk("R7 program in suspend op", arr_op, 1);
    chk("R7 program in suspend addr", arr_addr, 20'h40000);
    rd(20'h40000, s1); chk("R7 status bit7 during suspend program", s1[7], 0);
    wait_ready();
    #1 chk("R7 back to parked erase", arr_op, 0);

    // R7: resume
    wr(20'h00000, 8'h30); ref_ready = 1'b0;
    op_chk("R7 resume restarts erase", 2);
    wait_ready();

    // R3 / R7: chip erase, suspend ignored
    erase_pre(); wr(20'h00555, 8'h10); ref_ready = 1'b0;
    op_chk("R3 op chip erase", 3);
    wr(20'h00000, 8'hB0);
    op_chk("R7 chip erase not suspendable", 3);
    wait_ready();

    // R8: identification mode
    unl(); wr(20'h00555, 8'h90);
    rd(20'h00000, d); chk("R8 maker code", d, 8'h3C);
    rd(20'h00001, d); chk("R8 device code", d, 8'hA7);
    rd(20'h00002, d); chk("R8 protection code", d, 8'h00);
    wr(20'h00000, 8'hF0);
    rd(20'h00001, d); chk("R8 back to array", d, 8'h5B);

    // R9: timeout
    stall = 1'b1;
    prog(20'h50000, 8'h01); ref_ready = 1'b0;
    repeat (TOUT + 10) @(negedge clk);
    rd(20'h50000, s1);
    chk("R9 error bit", s1[5], 1);
    chk("R9 bit7 held", s1[7], 1);
    wr(20'h00000, 8'hF0); ref_ready = 1'b1; stall = 1'b0;
    op_chk("R9 recovered idle", 0);
    rd(20'h50000, d); chk("R9 array read after recovery", d, 8'h5A);

    // R10: reset mid-erase
    erase_pre(); wr(20'h60000, 8'h30); ref_ready = 1'b0;
    repeat (5) @(negedge clk);
    @(negedge clk); rst_n = 1'b0; ref_ready = 1'b1;
    #1;
    chk("R10 ready low in reset", ready, 0);
    chk("R10 job abandoned", arr_op, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1 chk("R10 ready after reset", ready, 1);
    rd(20'h60001, d); chk("R10 array read after reset", d, 8'h5B);

    repeat (4) @(negedge clk);
    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule